// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

The block is a bank of general-purpose pins behind a simple memory-mapped register port. Each pin has four 32-bit registers: control, I/O, interrupt configuration and interrupt status. Control holds the pull, function-select, drive-strength and output-enable settings. The pull and drive fields are only stored. When function select is 0, output enable and the output bit drive the pad. Any other function value hands the pad to an external function port. The I/O register returns the synchronized pad level and holds the output bit.

Each pin has its own event detector. It works on the synchronized pad level and supports four modes: level, rising edge, falling edge and both edges, each with a polarity bit. A detected event latches a sticky status bit, which software clears by writing zero to it. The configuration register shows the unmasked detector output as a read-only raw bit. It also holds an enable bit and a target field. The target picks which of several processor interrupt lines a pending, enabled pin drives. Target 3 is the application processor line.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, control and I/O registers read 0, no pad output is enabled and every interrupt line is low. The configuration register reads 0x10: level mode with polarity 0 sees the low pad as active, so the raw bit is set.
- R2: Control write stores pull in bit 0, function select in bits 5:2, drive strength in bits 8:6 and output enable in bit 9. Read-back returns these fields, with bit 1 and bits 31:10 reading 0.
- R3: With function select 0, pad_o follows I/O bit 1 and pad_oe_o follows control bit 9.
- R4: With a non-zero function select, pad_o follows alt_out_i and pad_oe_o follows alt_oe_i.
- R5: I/O bit 0 returns the pad level through a two-flop synchronizer. A change is not visible one clock edge after it and is visible after two.
- R6: Configuration bits 3:2 select the mode: 00 level, 01 rising, 10 falling, 11 both. Bit 1 is polarity. In rising mode with polarity 1, a 0-to-1 pad change latches status bit 0, and a 1-to-0 change does not.
- R7: In the single-edge modes, polarity 0 swaps the edge: rising mode then latches on falling edges. Falling mode with polarity 1 latches on falling edges only.
- R8: Both-edge mode latches status on either pad transition.
- R9: In level mode, polarity 1 is active-high and polarity 0 is active-low. While the active level holds, an acknowledge clears status for one cycle and status is set again on the next. Once the level is released, an acknowledge leaves status clear.
- R10: Writing 0 to status bit 0 clears it. Writing 1 leaves it unchanged. Edge-latched status stays set until acknowledged.
- R11: irq_o[t] is high when some pin has enable (configuration bit 0) = 1, status = 1 and target (bits 7:5) = t. Target 3 is the application processor line. Enable 0 keeps the pin off every line while its status still latches.
- R12: Configuration bit 4 reads the raw detector output whatever the enable bit.
- R13: Pin n's registers sit at 0x1000 + 0x10*n (control), +4 (I/O), +8 (configuration) and +0xC (status). Reads of a pin index at or above NUM_PINS, or outside the 0x1000 page, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid while req_i and not we_i |
| pad_i | input | NUM_PINS | Pad input levels (asynchronous) |
| alt_out_i | input | NUM_PINS | External function output value per pin |
| alt_oe_i | input | NUM_PINS | External function output enable per pin |
| pad_o | output | NUM_PINS | Pad output value |
| pad_oe_o | output | NUM_PINS | Pad output driver enable |
| irq_o | output | 2**TGT_W | Interrupt line per processor target |

## Verification
The hardest case to reach is the level-mode acknowledge. The status bit is clear for exactly one cycle between the acknowledge edge and the re-set edge. A register read cannot land in that cycle. The bench therefore samples irq_o directly, one nanosecond after the acknowledging write edge, and then reads status to see it set again. Edge polarity swapping is driven by toggling a pad in both directions under each mode. The pin is re-armed with an acknowledge before every step. This keeps a latch from an earlier edge from hiding a missing one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned FUNC_W = 4;
  localparam int unsigned DRV_W  = 3;
  localparam int unsigned REG_DW = 10;  // used write-data bits

  localparam int unsigned CTL_PULL = 0;
  localparam int unsigned CTL_FUNC = 2;
  localparam int unsigned CTL_DRV  = 6;
  localparam int unsigned CTL_OE   = 9;
  localparam int unsigned IO_OUT   = 1;
  localparam int unsigned IC_EN    = 0;
  localparam int unsigned IC_POL   = 1;
  localparam int unsigned IC_DET   = 2;
  localparam int unsigned IC_TGT   = 5;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'b00,
    DET_RISE  = 2'b01,
    DET_FALL  = 2'b10,
    DET_BOTH  = 2'b11
  } det_mode_e;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_IO   = 2'd1,
    SEL_ICFG = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      age_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  assign q_o = s2_q;

  // R5: output is the input two edges earlier
  a_r5_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det
  import gpio_bank_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  logic      pol_i,
  input  det_mode_e mode_i,
  input  logic      clr_i,
  output logic      raw_o,
  output logic      stat_o
);
  logic prev_q, stat_q;
  logic rise, fall, hit;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      DET_LEVEL: hit = (lvl_i == pol_i);
      DET_RISE:  hit = pol_i ? rise : fall;
      DET_FALL:  hit = pol_i ? fall : rise;
      default:   hit = rise | fall;
    endcase
  end

  // level: ack wins, re-set next cycle; edge: new event wins over ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (mode_i == DET_LEVEL) begin
        if (clr_i)    stat_q <= 1'b0;
        else if (hit) stat_q <= 1'b1;
      end else begin
        if (hit)        stat_q <= 1'b1;
        else if (clr_i) stat_q <= 1'b0;
      end
    end
  end

  assign raw_o  = hit;
  assign stat_o = stat_q;

  // R10: status only falls through an acknowledge
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o && !clr_i) |=> stat_o);

  // R6: a detected event is latched
  a_r6_event_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o && !clr_i) |=> stat_o);
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
  import gpio_bank_pkg::*;
#(
  parameter int unsigned TGT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              lvl_i,
  input  logic              alt_out_i,
  input  logic              alt_oe_i,
  output logic              pad_o,
  output logic              pad_oe_o,
  output logic              en_o,
  output logic              pend_o,
  output logic [TGT_W-1:0]  tgt_o
);
  logic              pull_q, oe_q, out_q, en_q, pol_q;
  logic [FUNC_W-1:0] func_q;
  logic [DRV_W-1:0]  drv_q;
  logic [TGT_W-1:0]  tgt_q;
  det_mode_e         det_q;
  logic              clr, raw, stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pull_q <= 1'b0;
      func_q <= '0;
      drv_q  <= '0;
      oe_q   <= 1'b0;
      out_q  <= 1'b0;
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
      det_q  <= DET_LEVEL;
      tgt_q  <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_CTL: begin
          pull_q <= wdata_i[CTL_PULL];
          func_q <= wdata_i[CTL_FUNC +: FUNC_W];
          drv_q  <= wdata_i[CTL_DRV +: DRV_W];
          oe_q   <= wdata_i[CTL_OE];
        end
        SEL_IO: out_q <= wdata_i[IO_OUT];
        SEL_ICFG: begin
          en_q  <= wdata_i[IC_EN];
          pol_q <= wdata_i[IC_POL];
          det_q <= det_mode_e'(wdata_i[IC_DET +: 2]);
          tgt_q <= wdata_i[IC_TGT +: TGT_W];
        end
        default: ;
      endcase
    end
  end

  assign clr = we_i && (sel_i == SEL_STAT) && !wdata_i[0];

  gpio_irq_det u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_i),
    .pol_i  (pol_q),
    .mode_i (det_q),
    .clr_i  (clr),
    .raw_o  (raw),
    .stat_o (stat)
  );

  always_comb begin
    unique case (sel_i)
      SEL_CTL:  rdata_o = {22'b0, oe_q, drv_q, func_q, 1'b0, pull_q};
      SEL_IO:   rdata_o = {30'b0, out_q, lvl_i};
      SEL_ICFG: rdata_o = {{(27-TGT_W){1'b0}}, tgt_q, raw, det_q, pol_q, en_q};
      default:  rdata_o = {31'b0, stat};
    endcase
  end

  assign pad_o    = (func_q == '0) ? out_q : alt_out_i;
  assign pad_oe_o = (func_q == '0) ? oe_q  : alt_oe_i;
  assign en_o     = en_q;
  assign pend_o   = stat;
  assign tgt_o    = tgt_q;

  // R10: writing 1 to status leaves a set bit set
  a_r10_write_one_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_STAT && wdata_i[0] && pend_o) |=> pend_o);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned TGT_W    = 3,
  parameter int unsigned ADDR_W   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PINS-1:0]   pad_i,
  input  logic [NUM_PINS-1:0]   alt_out_i,
  input  logic [NUM_PINS-1:0]   alt_oe_i,
  output logic [NUM_PINS-1:0]   pad_o,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [(1<<TGT_W)-1:0] irq_o
);
  localparam int unsigned NUM_TGT  = 1 << TGT_W;
  localparam int unsigned PAGE_LSB = 12;
  localparam int unsigned PAGE_W   = ADDR_W - PAGE_LSB;

  logic [7:0]          slot;
  logic                bank_hit;
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] lvl, pin_en, pin_pend;
  logic [31:0]         pin_rd  [NUM_PINS];
  logic [TGT_W-1:0]    pin_tgt [NUM_PINS];
  logic                wdata_unused;

  assign wdata_unused = ^{wdata_i[31:REG_DW], addr_i[1:0]};
  assign slot     = addr_i[11:4];
  assign sel      = reg_sel_e'(addr_i[3:2]);
  assign bank_hit = (addr_i[ADDR_W-1:PAGE_LSB] == PAGE_W'(1)) &&
                    ({24'b0, slot} < NUM_PINS);

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (lvl)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic pin_we;
    assign pin_we = req_i && we_i && bank_hit && (slot == 8'(i));

    gpio_pin #(.TGT_W(TGT_W)) u_pin (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (pin_we),
      .sel_i     (sel),
      .wdata_i   (wdata_i[REG_DW-1:0]),
      .rdata_o   (pin_rd[i]),
      .lvl_i     (lvl[i]),
      .alt_out_i (alt_out_i[i]),
      .alt_oe_i  (alt_oe_i[i]),
      .pad_o     (pad_o[i]),
      .pad_oe_o  (pad_oe_o[i]),
      .en_o      (pin_en[i]),
      .pend_o    (pin_pend[i]),
      .tgt_o     (pin_tgt[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (req_i && !we_i && bank_hit && slot == 8'(i)) rdata_o = pin_rd[i];
  end

  always_comb begin
    irq_o = '0;
    for (int t = 0; t < NUM_TGT; t++)
      for (int i = 0; i < NUM_PINS; i++)
        if (pin_en[i] && pin_pend[i] && pin_tgt[i] == TGT_W'(t)) irq_o[t] = 1'b1;
  end

  // R11: no enabled pin, no interrupt
  a_r11_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_en == '0) |-> (irq_o == '0));

  // R11: no pending pin, no interrupt
  a_r11_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pend == '0) |-> (irq_o == '0));
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pad = '0, alt_out = '0, alt_oe = '0;
  logic [3:0]  pad_o, pad_oe;
  logic [7:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;

  gpio_irq_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .alt_out_i(alt_out),
    .alt_oe_i(alt_oe), .pad_o(pad_o), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  function automatic logic [15:0] ra(int pin, int r);
    return 16'(16'h1000 + pin * 16 + r * 4);
  endfunction

  // monitor: pops expected read data
  always @(negedge clk) begin
    if (req && !we) begin
      sb_item_t it;
      n_tests++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: read got %h expected none", rdata);
      end else begin
        it = sb_q.pop_front();
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: read %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    addr = a; we = 1'b0; req = 1'b1;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1; req = 1'b1;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, e);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic arm(input int pin, input logic [31:0] cfg);
    wr(ra(pin, 2), cfg);
    cyc(2);
    wr(ra(pin, 3), 32'h0);
  endtask

  initial begin
    #(20 * 50000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(ra(0, 0), 32'h0, "R1 ctl");
    rd(ra(0, 1), 32'h0, "R1 io");
    rd(ra(0, 2), 32'h10, "R1 icfg raw");
    chk(32'(irq), 0, "R1 irq");
    chk(32'(pad_oe), 0, "R1 pad_oe");

    // R2 control storage
    wr(ra(1, 0), 32'hFFFF_FFFF);
    rd(ra(1, 0), 32'h3FD, "R2 ctl all ones");
    wr(ra(1, 0), 32'h0000_0245);
    rd(ra(1, 0), 32'h245, "R2 ctl pattern");
    wr(ra(1, 0), 32'h0);
    wr(ra(1, 1), 32'hFFFF_FFFF);
    rd(ra(1, 1), 32'h2, "R2 io out bit");

    // R3 gpio drive
    wr(ra(0, 0), 32'h200);
    wr(ra(0, 1), 32'h2);
    chk(32'(pad_o[0]), 1, "R3 pad_o high");
    chk(32'(pad_oe[0]), 1, "R3 oe high");
    wr(ra(0, 1), 32'h0);
    chk(32'(pad_o[0]), 0, "R3 pad_o low");
    wr(ra(0, 0), 32'h0);
    chk(32'(pad_oe[0]), 0, "R3 oe low");

    // R4 function handoff
    alt_out[2] = 1'b1; alt_oe[2] = 1'b1;
    wr(ra(2, 1), 32'h0);
    wr(ra(2, 0), 32'h0C);
    chk(32'(pad_o[2]), 1, "R4 alt out");
    chk(32'(pad_oe[2]), 1, "R4 alt oe");
    alt_out[2] = 1'b0; #1;
    chk(32'(pad_o[2]), 0, "R4 alt out low");

    // R5 synchronizer latency
    @(posedge clk); #1 pad[1] = 1'b1;
    rd(ra(1, 1), 32'h2, "R5 one edge");
    rd(ra(1, 1), 32'h3, "R5 two edges");
    pad[1] = 1'b0;

    // R6 rising pol1 to target 3
    arm(0, 32'h67);
    rd(ra(0, 3), 32'h0, "R6 armed");
    chk(32'(irq), 0, "R11 no irq armed");
    pad[0] = 1'b1; cyc(4);
    rd(ra(0, 3), 32'h1, "R6 rise latched");
    chk(32'(irq), 32'h8, "R11 app line");
    wr(ra(0, 3), 32'h1);
    rd(ra(0, 3), 32'h1, "R10 write one keeps");
    wr(ra(0, 3), 32'h0);
    rd(ra(0, 3), 32'h0, "R10 ack clears");
    pad[0] = 1'b0; cyc(4);
    rd(ra(0, 3), 32'h0, "R6 fall ignored");

    // R7 polarity swap and falling mode
    arm(0, 32'h65);
    pad[0] = 1'b1; cyc(4);
    rd(ra(0, 3), 32'h0, "R7 rise pol0 ignores rise");
    pad[0] = 1'b0; cyc(4);
    rd(ra(0, 3), 32'h1, "R7 rise pol0 fall");
    arm(0, 32'h6B);
    pad[0] = 1'b1; cyc(4);
    rd(ra(0, 3), 32'h0, "R7 fall ignores rise");
    pad[0] = 1'b0; cyc(4);
    rd(ra(0, 3), 32'h1, "R7 fall latched");

    // R8 both edges
    arm(0, 32'h6F);
    pad[0] = 1'b1; cyc(4);
    rd(ra(0, 3), 32'h1, "R8 rise");
    wr(ra(0, 3), 32'h0);
    rd(ra(0, 3), 32'h0, "R8 ack");
    pad[0] = 1'b0; cyc(4);
    rd(ra(0, 3), 32'h1, "R8 fall");

    // R9 level active-high, R12 raw
    arm(0, 32'h63);
    rd(ra(0, 3), 32'h0, "R9 idle low");
    pad[0] = 1'b1; cyc(4);
    rd(ra(0, 3), 32'h1, "R9 level set");
    rd(ra(0, 2), 32'h73, "R12 raw high");
    wr(ra(0, 2), 32'h62);
    rd(ra(0, 2), 32'h72, "R12 raw with enable off");
    chk(32'(irq), 0, "R11 enable off");
    wr(ra(0, 2), 32'h63);
    wr(ra(0, 3), 32'h0);
    chk(32'(irq), 0, "R9 ack cycle");
    rd(ra(0, 3), 32'h1, "R9 re-set while held");
    pad[0] = 1'b0; cyc(4);
    wr(ra(0, 3), 32'h0);
    rd(ra(0, 3), 32'h0, "R9 released");

    // R11 routing on pin 3
    arm(3, 32'h26);
    pad[3] = 1'b1; cyc(4);
    rd(ra(3, 3), 32'h1, "R11 status latches when disabled");
    chk(32'(irq), 0, "R11 disabled quiet");
    wr(ra(3, 2), 32'h27);
    chk(32'(irq), 32'h2, "R11 target 1");
    wr(ra(3, 2), 32'h67);
    chk(32'(irq), 32'h8, "R11 target 3");
    wr(ra(3, 3), 32'h0);
    chk(32'(irq), 0, "R11 ack drops line");

    // R13 unmapped
    rd(16'h1040, 32'h0, "R13 pin beyond bank");
    rd(16'h2008, 32'h0, "R13 other page");

    cyc(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule